// File: doc/BRIEF.md
# Serial Memory Read Slave

This block is the target side of a four-wire serial memory link. A 2048-byte array sits behind it. The chip select, serial clock, serial data in and pause pins all arrive asynchronous to the block. Each pin passes through a two-flop synchronizer, and the serial clock edges are found on the much faster system clock. An 8-bit instruction opens every selected transfer. Only two instructions are decoded.

The first is an array read. It takes a 16-bit address and then streams bytes out from that location, stepping the address after each byte. The second is a status read. It returns the two protection bits, the write-enable flag and the busy flag, which are supplied as level inputs.

A preload port lets the surrounding logic fill the array directly. The pause pin freezes a transfer mid-bit so that the bus master can serve another device and then continue.

Top module: `spi_mem_slave`

## Requirements
- R1: The link works with the serial clock idling low (mode 0) and with it idling high (mode 3). In both modes data in is taken on rising edges and data out changes after falling edges.
- R2: `so_oe` stays 0 while instruction and address bits are shifted in. Once output has begun, the level on `si` has no effect on the data returned.
- R3: Instruction 8'h03 is followed by a 16-bit address, most significant bit first. The first data bit (bit 7) is driven after the falling edge that follows the last address bit. Data is sent most significant bit first.
- R4: Only address bits 10..0 pick the location. Bits 15..11 are ignored.
- R5: After each byte the address steps by one, and location 2047 is followed by location 0.
- R6: Instruction 8'h05 returns {4'b0000, st_bp[1], st_bp[0], st_wen, st_busy}. The byte repeats while clocks continue.
- R7: Any other instruction keeps `so_oe` at 0 until chip select goes high.
- R8: A low level on `hold_n` forces `so_oe` to 0.
- R9: A pause starts or ends only while the serial clock is low. If `hold_n` changes while the clock is high, the change waits for the next falling edge. A falling edge that ends a pause is not counted.
- R10: While paused, clock and data transitions are ignored. The transfer then resumes at the exact bit where it stopped.
- R11: Chip select high aborts any command. The next selection decodes a fresh instruction.
- R12: A write on the preload port (`pre_we`) stores `pre_data` at `pre_addr`, and later reads return it.
- R13: During and right after reset, `so_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |
| st_bp | input | 2 | Protection bits reported by the status read |
| st_wen | input | 1 | Write-enable flag reported by the status read |
| st_busy | input | 1 | Busy flag reported by the status read |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 11 | Preload address |
| pre_data | input | 8 | Preload data |

## Verification
Array reads are tried with the following patterns, each separating a different fault:
- Reads from zero and from a mid-array address separate correct address assembly from bit-order and off-by-one-edge faults.
- A read starting two bytes below the top separates true wrap-around from saturation or a wider counter.
- An address with the upper five bits set catches leakage of ignored bits.
- The same read in mode 3 shows whether a leading falling edge is wrongly counted.

Two status reads with different flag inputs pin down each bit position. A foreign instruction, an aborted address phase and toggled `si` during output show that input is ignored where it must be. Two pause sequences are used:
- One is taken and released with the clock low.
- The other is taken and released with the clock high, which distinguishes a delayed release from an immediate one.

// File: rtl/spims_pkg.sv
package spims_pkg;

  localparam logic [7:0] OP_ARRAY_RD  = 8'h03;
  localparam logic [7:0] OP_STATUS_RD = 8'h05;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DATA,
    PH_STAT,
    PH_DEAD
  } phase_t;

  // Next array location, wrapping inside 2**aw bytes.
  function automatic logic [15:0] wrap_inc(input logic [15:0] a, input int unsigned aw);
    logic [15:0] mask;
    mask = 16'((32'd1 << aw) - 1);
    return (a + 16'd1) & mask;
  endfunction

  // Status byte: upper nibble zero, protection, write enable, busy.
  function automatic logic [7:0] pack_status(input logic [1:0] bp, input logic wen,
                                             input logic busy);
    return {4'b0000, bp, wen, busy};
  endfunction

endpackage

// File: rtl/spims_sync.sv
module spims_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[i];
        stab <= RST_VAL[i];
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/spims_hold.sv
module spims_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic held,
  output logic edge_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held <= 1'b0;
    else if (cs_n_s) held <= 1'b0;
    else if (!sck_s) held <= !hold_n_s;
  end

  assign edge_ok = !held;

  // A pause is entered only from a low serial clock.
  assert_enter_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(!sck_s));
  // Leaving a pause also needs a low serial clock.
  assert_leave_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(held) && !$past(cs_n_s)) |-> $past(!sck_s));
endmodule

// File: rtl/spims_mem.sv
module spims_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W = 11,
  parameter int WIRE_ADDR_W = 16,
  parameter int CMD_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  input  logic [1:0]        st_bp,
  input  logic              st_wen,
  input  logic              st_busy,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data
);
  import spims_pkg::*;

  localparam int CNT_W = $clog2(WIRE_ADDR_W + CMD_W);
  localparam int OB_W  = $clog2(DATA_W);

  // Synchronized pins, packed as {cs_n, sck, si, hold_n}.
  logic [3:0] pins_s;
  logic cs_n_s, sck_s, si_s, hold_n_s;
  spims_sync #(.W(4), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si, hold_n}), .q(pins_s));
  assign {cs_n_s, sck_s, si_s, hold_n_s} = pins_s;

  logic held, edge_ok;
  spims_hold u_hold (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_s(sck_s),
    .hold_n_s(hold_n_s), .held(held), .edge_ok(edge_ok));

  logic sck_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  // Named internal events.
  logic sck_rise, sck_fall;
  assign sck_rise = sck_s && !sck_q && edge_ok && !cs_n_s;
  assign sck_fall = !sck_s && sck_q && edge_ok && !cs_n_s;

  phase_t                  phase;
  logic [CNT_W-1:0]        bitcnt;
  logic [CMD_W-1:0]        cmd_sr;
  logic [WIRE_ADDR_W-1:0]  addr_sr;
  logic [ADDR_W-1:0]       addr;
  logic [OB_W-1:0]         obit;
  logic                    out_on;
  logic                    so_q;

  logic [DATA_W-1:0] mem_byte, cur_byte;
  spims_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .wr_en(pre_we), .wr_addr(pre_addr), .wr_data(pre_data),
    .rd_addr(addr), .rd_data(mem_byte));

  assign cur_byte = (phase == PH_STAT) ? DATA_W'(pack_status(st_bp, st_wen, st_busy))
                                       : mem_byte;

  logic [CMD_W-1:0]       cmd_next;
  logic [WIRE_ADDR_W-1:0] addr_next;
  logic                   addr_step;
  assign cmd_next  = {cmd_sr[CMD_W-2:0], si_s};
  assign addr_next = {addr_sr[WIRE_ADDR_W-2:0], si_s};
  assign addr_step = sck_fall && (phase == PH_DATA) && (obit == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CMD;
      bitcnt  <= '0;
      cmd_sr  <= '0;
      addr_sr <= '0;
      addr    <= '0;
      obit    <= OB_W'(DATA_W - 1);
      out_on  <= 1'b0;
      so_q    <= 1'b0;
    end else if (cs_n_s) begin
      phase  <= PH_CMD;
      bitcnt <= '0;
      obit   <= OB_W'(DATA_W - 1);
      out_on <= 1'b0;
    end else if (sck_rise) begin
      case (phase)
        PH_CMD: begin
          cmd_sr <= cmd_next;
          if (bitcnt == CNT_W'(CMD_W - 1)) begin
            bitcnt <= '0;
            obit   <= OB_W'(DATA_W - 1);
            if (cmd_next == OP_ARRAY_RD)       phase <= PH_ADDR;
            else if (cmd_next == OP_STATUS_RD) phase <= PH_STAT;
            else                               phase <= PH_DEAD;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        PH_ADDR: begin
          addr_sr <= addr_next;
          if (bitcnt == CNT_W'(WIRE_ADDR_W - 1)) begin
            bitcnt <= '0;
            addr   <= addr_next[ADDR_W-1:0];
            phase  <= PH_DATA;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        default: ;
      endcase
    end else if (sck_fall && (phase == PH_DATA || phase == PH_STAT)) begin
      so_q   <= cur_byte[obit];
      out_on <= 1'b1;
      if (obit == '0) begin
        obit <= OB_W'(DATA_W - 1);
        if (phase == PH_DATA) addr <= ADDR_W'(wrap_inc(16'(addr), ADDR_W));
      end else begin
        obit <= obit - 1'b1;
      end
    end
  end

  assign so    = so_q;
  assign so_oe = out_on && hold_n_s && !held && !cs_n_s;

  // Output stays off while instruction and address bits arrive.
  assert_quiet_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD || phase == PH_ADDR) |-> !so_oe);
  // Foreign instruction never enables output.
  assert_dead_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DEAD) |-> !so_oe);
  // Top location is followed by location zero.
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_step && addr == '1) |=> (addr == '0));
  // Paused transfer keeps its position.
  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_ok && !cs_n_s) |=> ($stable(bitcnt) && $stable(obit) && $stable(phase)));
  // Deselect returns to instruction decode.
  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (phase == PH_CMD && bitcnt == '0 && !out_on));
endmodule

// File: tb/spi_mem_slave_test.sv
module spi_mem_slave_test;
  localparam int HALF = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cs_n, sck, si, hold_n, so, so_oe;
  logic [1:0] st_bp;
  logic st_wen, st_busy, pre_we;
  logic [10:0] pre_addr;
  logic [7:0] pre_data;

  spi_mem_slave uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .st_bp(st_bp), .st_wen(st_wen), .st_busy(st_busy),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data));

  int total = 0;
  int bad = 0;

  function automatic logic [7:0] fill(input int a);
    return 8'(((a * 37) ^ (a >> 3)) ^ 8'h5A);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pause(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic r, output logic o);
    sck = 1'b0; si = b;
    pause(HALF);
    r = so; o = so_oe;
    sck = 1'b1;
    pause(HALF);
  endtask

  task automatic sel(input logic mode);
    sck = mode; pause(HALF);
    cs_n = 1'b0; pause(HALF);
  endtask

  task automatic desel(input logic mode);
    if (!mode) begin sck = 1'b0; pause(HALF); end
    cs_n = 1'b1; pause(HALF);
  endtask

  // Shift n bits in, MSB first; reports whether output was ever enabled.
  task automatic send(input logic [23:0] v, input int n, inout logic seen_oe);
    logic r, o;
    for (int i = n - 1; i >= 0; i--) begin
      bit_io(v[i], r, o);
      if (o) seen_oe = 1'b1;
    end
  endtask

  // Shift n bits out, MSB first; si toggles as garbage.
  task automatic recv(input int n, output logic [7:0] val, output logic all_oe);
    logic r, o;
    val = '0; all_oe = 1'b1;
    for (int i = 0; i < n; i++) begin
      bit_io(i[0], r, o);
      val = {val[6:0], r};
      if (!o) all_oe = 1'b0;
    end
  endtask

  typedef struct packed {
    logic        mode;
    logic [7:0]  op;
    logic [15:0] addr;
    logic [3:0]  nbytes;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 8'h03, 16'h0000, 4'd3},
    '{1'b1, 8'h03, 16'h0123, 4'd2},
    '{1'b0, 8'h03, 16'h07FE, 4'd4},
    '{1'b0, 8'h03, 16'hF812, 4'd2},
    '{1'b1, 8'h05, 16'h0000, 4'd2},
    '{1'b0, 8'h9F, 16'h0000, 4'd2}
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic seen, alloe;
    logic [7:0] got, exp;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1;
    st_bp = 2'b10; st_wen = 1'b1; st_busy = 1'b0;
    pre_we = 1'b0; pre_addr = '0; pre_data = '0;
    pause(5);
    chk(so_oe == 1'b0, "R13 reset", so_oe, 0);
    rst_n = 1'b1;
    pause(5);
    chk(so_oe == 1'b0, "R13 after reset", so_oe, 0);

    // R12 preload the whole array
    for (int a = 0; a < 2048; a++) begin
      pre_we = 1'b1; pre_addr = 11'(a); pre_data = fill(a);
      pause(1);
    end
    pre_we = 1'b0;
    pause(2);

    // Vector walk: R1 R2 R3 R4 R5 R6 R7 R12
    foreach (VECS[k]) begin
      vec_t v;
      v = VECS[k];
      seen = 1'b0;
      sel(v.mode);
      send({16'h0, v.op}, 8, seen);
      if (v.op == 8'h03) send({8'h0, v.addr}, 16, seen);
      if (v.op == 8'h03 || v.op == 8'h05) begin
        chk(!seen, "R2 quiet during input", seen, 0);
        for (int b = 0; b < int'(v.nbytes); b++) begin
          recv(8, got, alloe);
          if (v.op == 8'h05) exp = {4'b0000, st_bp, st_wen, st_busy};
          else exp = fill((int'(v.addr[10:0]) + b) % 2048);
          chk(got == exp && alloe,
              v.op == 8'h05 ? "R6 status" : "R3 R4 R5 R1 R12 read data", got, exp);
        end
      end else begin
        send(24'hFFFFFF, 24, seen);
        chk(!seen, "R7 unknown opcode stays off", seen, 0);
      end
      desel(v.mode);
    end

    // R6 second flag pattern
    st_bp = 2'b01; st_wen = 1'b0; st_busy = 1'b1;
    seen = 1'b0;
    sel(1'b0);
    send({16'h0, 8'h05}, 8, seen);
    recv(8, got, alloe);
    chk(got == 8'h05 && alloe, "R6 status flags", got, 8'h05);
    desel(1'b0);

    // R11 abort in the address phase, then a fresh read
    seen = 1'b0;
    sel(1'b0);
    send({16'h0, 8'h03}, 8, seen);
    send(24'h3FF, 10, seen);
    desel(1'b0);
    sel(1'b0);
    send({16'h0, 8'h03}, 8, seen);
    send(24'h0040, 16, seen);
    recv(8, got, alloe);
    chk(got == fill(16'h40) && alloe, "R11 read after abort", got, fill(16'h40));
    desel(1'b0);

    // R10 pause taken and released with the clock low, during input
    seen = 1'b0;
    sel(1'b0);
    send(24'h0, 4, seen);
    sck = 1'b0; pause(HALF);
    hold_n = 1'b0; pause(HALF);
    for (int i = 0; i < 3; i++) begin
      si = 1'b1; sck = 1'b1; pause(HALF); sck = 1'b0; pause(HALF);
    end
    hold_n = 1'b1; pause(HALF);
    send(24'h3, 4, seen);
    send(24'h0200, 16, seen);
    recv(8, got, alloe);
    chk(got == fill(16'h200) && alloe, "R10 resume in input", got, fill(16'h200));
    recv(8, got, alloe);
    chk(got == fill(16'h201) && alloe, "R10 R5 next byte", got, fill(16'h201));
    desel(1'b0);

    // R8 R9 R10 pause taken and released with the clock high, during output
    seen = 1'b0;
    sel(1'b0);
    send({16'h0, 8'h03}, 8, seen);
    send(24'h0300, 16, seen);
    begin
      logic [7:0] hi, lo;
      recv(3, hi, alloe);
      hold_n = 1'b0; pause(4);
      chk(so_oe == 1'b0, "R8 hold forces high impedance", so_oe, 0);
      sck = 1'b0; pause(HALF);
      si = 1'b1; sck = 1'b1; pause(HALF);
      sck = 1'b0; pause(HALF);
      sck = 1'b1; pause(HALF);
      hold_n = 1'b1; pause(HALF);
      chk(so_oe == 1'b0, "R9 release waits for falling edge", so_oe, 0);
      recv(5, lo, alloe);
      got = {hi[2:0], lo[4:0]};
      chk(got == fill(16'h300) && alloe, "R9 R10 resume in output", got, fill(16'h300));
    end
    recv(8, got, alloe);
    chk(got == fill(16'h301) && alloe, "R10 following byte", got, fill(16'h301));
    desel(1'b0);

    pause(4);
    chk(so_oe == 1'b0, "R11 off after deselect", so_oe, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule